// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is the slave end of a four-wire SPI link, working in clock mode 0, that behaves like a small serial EEPROM of 2^ADDR_W bytes (1024 by default). The SPI lines are sampled by the system clock, so SCLK must be several times slower than `clk_i`. Each frame starts when chip select falls and begins with an 8-bit instruction. The instruction may be followed by a 16-bit address and then data.

A status register holds a busy flag, a write-enable latch, a two-bit protection field and a lock bit. Data and status writes are collected during the frame and take effect only when chip select rises. A programmable busy period then stands in for the internal write cycle. During the busy period the buffered data bytes are written into the array one per clock, and any byte whose address is protected is skipped.

Top module: `spi_eeprom_slave`

## Requirements
- R1: Bits travel MSB first. MOSI is sampled on SCLK rising edges and MISO changes on falling edges. The opcodes are 0x06 set latch, 0x04 clear latch, 0x05 read status, 0x01 write status, 0x03 read data and 0x02 write data. Any other opcode is ignored.
- R2: The status byte reads as {lock, 0, 0, 0, prot[1:0], latch, busy}, with busy in bit 0. Opcode 0x05 returns the current status in every following byte of the frame.
- R3: A completed 0x06 instruction sets the write-enable latch and a completed 0x04 instruction clears it.
- R4: Opcodes 0x02 and 0x01 are ignored unless the latch is set. When ignored they change neither the array nor the status.
- R5: A write takes effect only when chip select rises with no partial byte pending. A rise of chip select in the middle of a byte aborts the whole frame.
- R6: A committed write sets busy for BUSY_CYCLES clocks, and the latch clears when busy ends. While busy, every opcode except 0x05 is ignored.
- R7: For 0x03, the two address bytes are sent MSB first and only the low ADDR_W bits are used. The block then streams bytes from successive addresses, wrapping from the top address to 0, until chip select rises.
- R8: The protection field selects which data writes are dropped: 00 drops none, 01 drops the top quarter (0x300-0x3FF), 10 drops the top half (0x200-0x3FF) and 11 drops every address.
- R9: While the lock bit (status bit 7) is 1, opcode 0x01 has no effect.
- R10: MISO is high impedance and `miso_oe_o` is 0 whenever chip select is high. Both drive while chip select is low.
- R11: A 0x02 frame buffers at most PAGE_BYTES data bytes, starting at the address sent and counting upward. Any further bytes in that frame are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; it samples all SPI lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | SPI serial clock, idle low |
| mosi_i | input | 1 | Serial data into the block |
| miso_o | output | 1 | Serial data out of the block; high impedance while deselected |
| miso_oe_o | output | 1 | High while MISO is driven |

## Verification
The assertions assume the following about the SPI lines:
- SCLK is idle low when chip select falls.
- Each SCLK phase lasts longer than the three-flop synchronizer, so an edge is never missed and never merged with the next.
- Chip select never changes within a few clocks of an SCLK edge.

The bench holds every SCLK phase for eight system clocks. It changes MOSI and chip select only while SCLK is low, eight clocks away from any edge. It waits out the full busy period whenever a later step needs the array to be settled.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_RDATA, ST_WDATA, ST_RSTAT, ST_WSTAT, ST_SKIP
  } ee_state_e;

  // top: two most significant address bits
  function automatic logic in_prot(input logic [1:0] bp, input logic [1:0] top);
    case (bp)
      2'b00:   in_prot = 1'b0;
      2'b01:   in_prot = (top == 2'b11);
      2'b10:   in_prot = top[1];
      default: in_prot = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_ee_link.sv
module spi_ee_link (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic [7:0] rx_byte_o,
  output logic       rx_vld_o,
  output logic       cs_end_o,
  output logic       cs_whole_o,
  output logic       sel_o,
  output logic       miso_bit_o
);
  logic [2:0] sclk_s, cs_s;
  logic [1:0] mosi_s;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       rx_vld_q;
  logic       sck_rise, sck_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_s <= '0;
      cs_s   <= '1;
      mosi_s <= '0;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk_i};
      cs_s   <= {cs_s[1:0], cs_ni};
      mosi_s <= {mosi_s[0], mosi_i};
    end
  end

  assign sck_rise = sclk_s[1] & ~sclk_s[2];
  assign sck_fall = ~sclk_s[1] & sclk_s[2];
  assign sel_o    = ~cs_s[1];
  assign cs_end_o = cs_s[1] & ~cs_s[2];
  // bit_cnt still holds its in-frame value in the cycle of the rise
  assign cs_whole_o = cs_end_o && (bit_cnt == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_vld_q <= 1'b0;
    end else if (!sel_o) begin
      bit_cnt  <= '0;
      tx_sh    <= '0;
      rx_vld_q <= 1'b0;
    end else begin
      rx_vld_q <= 1'b0;
      if (sck_rise) begin
        rx_sh   <= {rx_sh[6:0], mosi_s[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) rx_vld_q <= 1'b1;
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) tx_sh <= tx_byte_i;
        else                 tx_sh <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  assign rx_byte_o  = rx_sh;
  assign rx_vld_o   = rx_vld_q;
  assign miso_bit_o = tx_sh[7];

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        rx_byte_i,
  input  logic              rx_vld_i,
  input  logic              cs_end_i,
  input  logic              cs_whole_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        tx_byte_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int IW = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam int BW = $clog2(BUSY_CYCLES);
  localparam logic [CW-1:0] PAGE_C = CW'(PAGE_BYTES);
  localparam logic [BW-1:0] BUSY_LAST = BW'(BUSY_CYCLES - 1);

  ee_state_e         state_q;
  logic              wel_q, wip_q, srwd_q, srwd_new_q, sr_got_q, rd_q;
  logic [1:0]        bp_q, bp_new_q;
  logic [7:0]        addr_hi_q;
  logic [ADDR_W-1:0] addr_q, cbase_q;
  logic [CW-1:0]     wcnt_q, cidx_q, cnum_q;
  logic [BW-1:0]     busy_q;
  logic [7:0]        wbuf [PAGE_BYTES];
  logic [7:0]        status;

  assign status = {srwd_q, 3'b000, bp_q, wel_q, wip_q};

  always_comb begin
    case (state_q)
      ST_RSTAT: tx_byte_o = status;
      ST_RDATA: tx_byte_o = mem_rdata_i;
      default:  tx_byte_o = 8'h00;
    endcase
  end

  assign mem_raddr_o = addr_q;
  assign mem_waddr_o = cbase_q + ADDR_W'(cidx_q);
  assign mem_wdata_o = wbuf[cidx_q[IW-1:0]];
  assign mem_we_o    = wip_q && (cidx_q != cnum_q)
                       && !in_prot(bp_q, mem_waddr_o[ADDR_W-1:ADDR_W-2]);

  always_ff @(posedge clk_i) begin
    if (rx_vld_i && state_q == ST_WDATA && wcnt_q != PAGE_C)
      wbuf[wcnt_q[IW-1:0]] <= rx_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OPC;
      wel_q <= 1'b0; wip_q <= 1'b0; srwd_q <= 1'b0; bp_q <= '0;
      srwd_new_q <= 1'b0; bp_new_q <= '0; sr_got_q <= 1'b0; rd_q <= 1'b0;
      addr_hi_q <= '0; addr_q <= '0; cbase_q <= '0;
      wcnt_q <= '0; cidx_q <= '0; cnum_q <= '0; busy_q <= '0;
    end else begin
      if (wip_q) begin
        if (cidx_q != cnum_q) cidx_q <= cidx_q + 1'b1;
        if (busy_q == '0) begin
          wip_q <= 1'b0;
          wel_q <= 1'b0;
        end else begin
          busy_q <= busy_q - 1'b1;
        end
      end
      if (cs_end_i) begin
        state_q <= ST_OPC;
        if (cs_whole_i && state_q == ST_WDATA && wcnt_q != '0) begin
          wip_q <= 1'b1; busy_q <= BUSY_LAST;
          cnum_q <= wcnt_q; cidx_q <= '0; cbase_q <= addr_q;
        end else if (cs_whole_i && state_q == ST_WSTAT && sr_got_q) begin
          bp_q <= bp_new_q; srwd_q <= srwd_new_q;
          wip_q <= 1'b1; busy_q <= BUSY_LAST;
          cnum_q <= '0; cidx_q <= '0;
        end
      end else if (rx_vld_i) begin
        case (state_q)
          ST_OPC: begin
            wcnt_q   <= '0;
            sr_got_q <= 1'b0;
            if (wip_q && rx_byte_i != OP_RDSR) state_q <= ST_SKIP;
            else begin
              case (rx_byte_i)
                OP_WREN:  begin wel_q <= 1'b1; state_q <= ST_SKIP; end
                OP_WRDI:  begin wel_q <= 1'b0; state_q <= ST_SKIP; end
                OP_RDSR:  state_q <= ST_RSTAT;
                OP_READ:  begin rd_q <= 1'b1; state_q <= ST_AHI; end
                OP_WRITE: begin
                  rd_q    <= 1'b0;
                  state_q <= wel_q ? ST_AHI : ST_SKIP;
                end
                OP_WRSR:  state_q <= (wel_q && !srwd_q) ? ST_WSTAT : ST_SKIP;
                default:  state_q <= ST_SKIP;
              endcase
            end
          end
          ST_AHI: begin addr_hi_q <= rx_byte_i; state_q <= ST_ALO; end
          ST_ALO: begin
            addr_q  <= ADDR_W'({addr_hi_q, rx_byte_i});
            state_q <= rd_q ? ST_RDATA : ST_WDATA;
          end
          ST_RDATA: addr_q <= addr_q + 1'b1;
          ST_WDATA: if (wcnt_q != PAGE_C) wcnt_q <= wcnt_q + 1'b1;
          ST_WSTAT: if (!sr_got_q) begin
            bp_new_q   <= rx_byte_i[3:2];
            srwd_new_q <= rx_byte_i[7];
            sr_got_q   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  busy_needs_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> wel_q);
  // R6
  wel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_q) |-> !wel_q);
  // R6
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip_q && rx_vld_i && !cs_end_i && state_q == ST_OPC)
      |=> (state_q == ST_RSTAT || state_q == ST_SKIP));
  // R9
  srwd_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srwd_q |=> (srwd_q && $stable(bp_q)));
  // R4
  wdata_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WDATA) |-> (wel_q && !wip_q));

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int ADDR_W      = 10,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        rx_byte, tx_byte, mem_rdata, mem_wdata;
  logic              rx_vld, cs_end, cs_whole, sel, miso_bit, mem_we;
  logic [ADDR_W-1:0] mem_raddr, mem_waddr;
  logic [7:0]        mem [DEPTH];

  spi_ee_link u_link (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .mosi_i,
    .tx_byte_i (tx_byte),
    .rx_byte_o (rx_byte),
    .rx_vld_o  (rx_vld),
    .cs_end_o  (cs_end),
    .cs_whole_o(cs_whole),
    .sel_o     (sel),
    .miso_bit_o(miso_bit)
  );

  spi_ee_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .rx_byte_i  (rx_byte),
    .rx_vld_i   (rx_vld),
    .cs_end_i   (cs_end),
    .cs_whole_i (cs_whole),
    .mem_rdata_i(mem_rdata),
    .tx_byte_o  (tx_byte),
    .mem_raddr_o(mem_raddr),
    .mem_we_o   (mem_we),
    .mem_waddr_o(mem_waddr),
    .mem_wdata_o(mem_wdata)
  );

  always_ff @(posedge clk_i) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end
  assign mem_rdata = mem[mem_raddr];

  assign miso_oe_o = sel;
  assign miso_o    = sel ? miso_bit : 1'bz;

  // R10
  miso_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_end |-> !miso_oe_o);
  // R8
  prot_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !(spi_ee_pkg::in_prot(u_ctrl.bp_q, mem_waddr[ADDR_W-1:ADDR_W-2])));

endmodule

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;
  localparam int BUSY = 1500;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  wire  miso, miso_oe;
  int   n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$], act_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  spi_eeprom_slave #(.ADDR_W(10), .PAGE_BYTES(4), .BUSY_CYCLES(BUSY)) u_spi_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares received bytes against the scoreboard queue
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0)
      check(act_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic xbits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = d[i]; clk_wait(HALF);
      sclk = 1'b1; clk_wait(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] d, input bit chk,
                       input logic [7:0] exp, input string req);
    logic [7:0] r;
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i]; clk_wait(HALF);
      r[i] = miso;
      sclk = 1'b1; clk_wait(HALF);
      sclk = 1'b0;
    end
    if (chk) begin exp_q.push_back(exp); tag_q.push_back(req); act_q.push_back(r); end
  endtask

  task automatic cs_lo; cs_n = 1'b0; clk_wait(HALF); endtask
  task automatic cs_hi; clk_wait(HALF); cs_n = 1'b1; clk_wait(HALF); endtask

  task automatic cmd(input logic [7:0] op);
    cs_lo(); xbyte(op, 0, 0, ""); cs_hi();
  endtask

  task automatic rdsr(input logic [7:0] exp, input string req);
    cs_lo(); xbyte(8'h05, 0, 0, ""); xbyte(8'h00, 1, exp, req); xbyte(8'h00, 1, exp, req); cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_lo(); xbyte(8'h01, 0, 0, ""); xbyte(v, 0, 0, ""); cs_hi();
  endtask

  task automatic hdr(input logic [7:0] op, input logic [7:0] ah, input logic [7:0] al);
    cs_lo(); xbyte(op, 0, 0, ""); xbyte(ah, 0, 0, ""); xbyte(al, 0, 0, "");
  endtask

  task automatic wr1(input logic [9:0] a, input logic [7:0] d);
    hdr(8'h02, {6'b0, a[9:8]}, a[7:0]); xbyte(d, 0, 0, ""); cs_hi();
  endtask

  task automatic rd1(input logic [9:0] a, input logic [7:0] exp, input string req);
    hdr(8'h03, {6'b0, a[9:8]}, a[7:0]); xbyte(8'h00, 1, exp, req); cs_hi();
  endtask

  task automatic settle; clk_wait(BUSY + 100); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    clk_wait(5); rst_n = 1'b1; clk_wait(5);
    // R10 released while deselected, driven while selected
    check({7'b0, miso_oe}, 8'h00, "R10");
    cs_lo(); check({7'b0, miso_oe}, 8'h01, "R10"); cs_hi();
    check({7'b0, miso_oe}, 8'h00, "R10");
    rdsr(8'h00, "R2");                       // reset status
    cmd(8'h06); rdsr(8'h02, "R3");
    cmd(8'h04); rdsr(8'h00, "R3");
    cmd(8'hAB); rdsr(8'h00, "R1");           // unknown opcode ignored
    // R6 busy window
    cmd(8'h06); wr1(10'h010, 8'h5A);
    rdsr(8'h03, "R6");
    cmd(8'h04); rdsr(8'h03, "R6");           // clear-latch ignored while busy
    settle(); rdsr(8'h00, "R6");
    rd1(10'h010, 8'h5A, "R1");
    // R4 write without latch
    wr1(10'h010, 8'hA5); rdsr(8'h00, "R4"); rd1(10'h010, 8'h5A, "R4");
    // R7 wrap and upper address bits ignored
    cmd(8'h06); hdr(8'h02, 8'hFF, 8'hFE);
    xbyte(8'h11, 0, 0, ""); xbyte(8'h22, 0, 0, ""); xbyte(8'h33, 0, 0, ""); cs_hi(); settle();
    hdr(8'h03, 8'h03, 8'hFE);
    xbyte(0, 1, 8'h11, "R7"); xbyte(0, 1, 8'h22, "R7"); xbyte(0, 1, 8'h33, "R7"); cs_hi();
    // R11 page limit
    cmd(8'h06); wr1(10'h104, 8'hC4); settle();
    cmd(8'h06); hdr(8'h02, 8'h01, 8'h00);
    for (int i = 0; i < 6; i++) xbyte(8'hB0 + 8'(i), 0, 0, "");
    cs_hi(); settle();
    hdr(8'h03, 8'h01, 8'h00);
    for (int i = 0; i < 4; i++) xbyte(0, 1, 8'hB0 + 8'(i), "R11");
    xbyte(0, 1, 8'hC4, "R11"); cs_hi();
    // R5 partial byte aborts
    cmd(8'h06); hdr(8'h02, 8'h00, 8'h10); xbyte(8'h77, 0, 0, ""); xbits(8'hF0, 4); cs_hi();
    rdsr(8'h02, "R5"); rd1(10'h010, 8'h5A, "R5");
    // R6 read ignored while busy
    wr1(10'h011, 8'h3C);
    hdr(8'h03, 8'h00, 8'h10); xbyte(0, 1, 8'h00, "R6"); cs_hi(); settle();
    rd1(10'h011, 8'h3C, "R6");
    // R8 protection ranges
    cmd(8'h06); wrsr(8'h04); rdsr(8'h07, "R2"); settle(); rdsr(8'h04, "R8");
    cmd(8'h06); wr1(10'h3FE, 8'h99); settle(); rd1(10'h3FE, 8'h11, "R8");
    cmd(8'h06); wr1(10'h2FF, 8'hE1); settle(); rd1(10'h2FF, 8'hE1, "R8");
    cmd(8'h06); wrsr(8'h08); settle();
    cmd(8'h06); wr1(10'h2FF, 8'hE2); settle(); rd1(10'h2FF, 8'hE1, "R8");
    cmd(8'h06); wr1(10'h100, 8'hD0); settle(); rd1(10'h100, 8'hD0, "R8");
    cmd(8'h06); wrsr(8'h0C); settle();
    cmd(8'h06); wr1(10'h010, 8'h00); settle(); rd1(10'h010, 8'h5A, "R8");
    // R9 lock, bits 6:4 stay 0
    cmd(8'h06); wrsr(8'hFF); settle(); rdsr(8'h8C, "R2");
    cmd(8'h06); wrsr(8'h00); rdsr(8'h8E, "R9");
    clk_wait(20);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule